// File: doc/BRIEF.md
# Windowed Byte-Rate Limiter

This block caps the bandwidth of one switch port. It runs one decision channel for received frames and one for transmitted frames. At the start of each frame a channel is given the frame's byte length and a priority bit. Two cycles later it answers with a single admit or drop decision. Each channel keeps byte counters that are cleared at every window boundary. A frame is admitted only while the counter for its class stays within a budget. That budget comes from an 8-bit rate value in steps of 4000 bytes per window, which is 32 kbps over a one-second window.

A free-running divider makes the window boundary from the system clock. The divider length is a parameter, so one second of real time can be shortened in simulation. Each channel has two rate values, one for high-priority and one for low-priority traffic, and an enable bit for each class. A differential-mode bit chooses between one counter per class and a single counter shared by both classes. The shared counter is governed by the high-priority rate and enable.

Each channel is a two-state machine. In ST_IDLE the channel waits for a start strobe. A strobe captures the length and priority and takes the transition IDLE→CHECK. In ST_CHECK the channel compares against the budget, updates the counter, registers the decision and takes the unconditional transition CHECK→IDLE.

Top module: `port_rate_limiter`

## Requirements
- R1: A window boundary occurs once every WINDOW_CYCLES clock cycles, counted from reset release. At a boundary every byte counter of both channels returns to zero.
- R2: A start strobe sampled in ST_IDLE at clock edge k produces a decision (dec_valid = 1) for exactly one cycle, starting at edge k+1.
- R3: A start strobe sampled while the channel is in ST_CHECK, the cycle after an accepted strobe, is ignored. It produces no decision and charges no bytes.
- R4: When the enable bit of the governing class is 0, every frame is admitted (dec_admit = 1) whatever the rate value, and its bytes are not counted.
- R5: When the governing enable is 1, a frame is admitted exactly when the counter plus the frame length is at most rate × 4000. A total equal to the budget is admitted.
- R6: With the governing enable at 1 and a rate of 0, every frame of that class is dropped.
- R7: An admitted, limited frame adds its length to its counter. A dropped frame adds nothing.
- R8: With differential mode 0, high- and low-priority frames share one counter, governed by the high-priority rate and enable. The low-priority settings are not used.
- R9: With differential mode 1, each class uses its own counter, rate and enable, and the two classes do not consume each other's budget.
- R10: The receive and transmit channels keep separate counters. Traffic on one never changes the decisions of the other.
- R11: After reset no decision is presented and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_start | input | 1 | Receive frame start strobe |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_hi | input | 1 | Receive frame is high priority |
| tx_start | input | 1 | Transmit frame start strobe |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_hi | input | 1 | Transmit frame is high priority |
| rx_rate_hi | input | RATE_W | Receive high-priority rate, 4000-byte steps |
| rx_rate_lo | input | RATE_W | Receive low-priority rate, 4000-byte steps |
| rx_en_hi | input | 1 | Receive high-priority limiting enable |
| rx_en_lo | input | 1 | Receive low-priority limiting enable |
| rx_diff | input | 1 | Receive differential per-class mode |
| tx_rate_hi | input | RATE_W | Transmit high-priority rate, 4000-byte steps |
| tx_rate_lo | input | RATE_W | Transmit low-priority rate, 4000-byte steps |
| tx_en_hi | input | 1 | Transmit high-priority limiting enable |
| tx_en_lo | input | 1 | Transmit low-priority limiting enable |
| tx_diff | input | 1 | Transmit differential per-class mode |
| rx_dec_valid | output | 1 | Receive decision valid, one cycle |
| rx_dec_admit | output | 1 | Receive decision: 1 admit, 0 drop |
| tx_dec_valid | output | 1 | Transmit decision valid, one cycle |
| tx_dec_admit | output | 1 | Transmit decision: 1 admit, 0 drop |

## Verification
The assertions check several properties on every cycle:
- the two-cycle decision latency and its one-cycle width;
- that a boundary seen in ST_IDLE leaves both counters at zero;
- that counters never exceed the largest budget;
- that a drop leaves the counters unchanged;
- that an unlimited class is always admitted.

Some behaviour can only be shown by the bench's scenarios, because it depends on what happened earlier in the window. This covers the exact budget edge, blocking at rate 0, sharing of one counter when differential mode is off, and independence of classes and of directions. The same holds for the strobe that arrives while a channel is busy and the refill of the budget after a boundary.

// File: rtl/rl_pkg.sv
package rl_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_CHECK = 1'b1
    } chan_state_t;

    localparam int NUM_CHAN = 2;
endpackage

// File: rtl/rl_window_timer.sv
module rl_window_timer #(
    parameter int WINDOW_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick = (div_q == LAST);

    generate
        if (WINDOW_CYCLES > 1) begin : g_spacing
            // R1: boundaries never come on consecutive cycles
            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/rl_channel.sv
module rl_channel
    import rl_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int RATE_W     = 8,
    parameter int STEP_BYTES = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              hi,
    input  logic [RATE_W-1:0] rate_hi,
    input  logic [RATE_W-1:0] rate_lo,
    input  logic              en_hi,
    input  logic              en_lo,
    input  logic              diff,
    output logic              dec_valid,
    output logic              dec_admit
);
    localparam int MAX_BUDGET = ((1 << RATE_W) - 1) * STEP_BYTES;
    localparam int BUDGET_W   = $clog2(MAX_BUDGET + 1);
    localparam int CNT_W      = ((BUDGET_W > LEN_W) ? BUDGET_W : LEN_W) + 1;

    chan_state_t       st, st_nxt;
    logic [LEN_W-1:0]  len_q;
    logic              hi_q;
    logic [CNT_W-1:0]  cnt_hi, cnt_lo, nxt_hi, nxt_lo;
    logic              use_lo, en_sel, fits, admit_now, charge;
    logic [RATE_W-1:0] rate_sel;
    logic [CNT_W-1:0]  base, sum, budget;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (start) st_nxt = ST_CHECK;
            ST_CHECK: st_nxt = ST_IDLE;
        endcase
    end

    // capture of the frame descriptor on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            hi_q  <= 1'b0;
        end else if (st == ST_IDLE && start) begin
            len_q <= len;
            hi_q  <= hi;
        end
    end

    // class selection and budget comparison
    always_comb begin
        use_lo    = diff && !hi_q;
        rate_sel  = use_lo ? rate_lo : rate_hi;
        en_sel    = use_lo ? en_lo : en_hi;
        base      = tick ? '0 : (use_lo ? cnt_lo : cnt_hi);
        sum       = base + CNT_W'(len_q);
        budget    = CNT_W'(rate_sel) * CNT_W'(STEP_BYTES);
        fits      = (sum <= budget);
        admit_now = !en_sel || fits;
        charge    = en_sel && fits;
    end

    always_comb begin
        nxt_hi = tick ? '0 : cnt_hi;
        nxt_lo = tick ? '0 : cnt_lo;
        if (st == ST_CHECK && charge) begin
            if (use_lo) nxt_lo = sum;
            else        nxt_hi = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_hi <= '0;
            cnt_lo <= '0;
        end else begin
            cnt_hi <= nxt_hi;
            cnt_lo <= nxt_lo;
        end
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_admit <= 1'b0;
        end else begin
            dec_valid <= (st == ST_CHECK);
            dec_admit <= (st == ST_CHECK) ? admit_now : 1'b0;
        end
    end

    // R2: decision follows an accepted strobe after two edges
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> ##1 dec_valid);
    // R2: decision lasts a single cycle
    a_r2_single: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    // R1: a boundary in idle empties both counters
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && st == ST_IDLE) |=> (cnt_hi == '0 && cnt_lo == '0));
    // R7: a drop charges nothing
    a_r7_no_charge: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !tick && !admit_now) |=>
        (cnt_hi == $past(cnt_hi) && cnt_lo == $past(cnt_lo)));
    // R5: counters stay inside the largest budget
    a_r5_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hi <= CNT_W'(MAX_BUDGET) && cnt_lo <= CNT_W'(MAX_BUDGET)));
    // R4: an unlimited class is always admitted
    a_r4_free_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !en_sel) |=> dec_admit);
endmodule

// File: rtl/port_rate_limiter.sv
module port_rate_limiter
    import rl_pkg::*;
#(
    parameter int LEN_W         = 11,
    parameter int RATE_W        = 8,
    parameter int STEP_BYTES    = 4000,
    parameter int WINDOW_CYCLES = 50_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_start,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic              rx_hi,
    input  logic              tx_start,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              tx_hi,
    input  logic [RATE_W-1:0] rx_rate_hi,
    input  logic [RATE_W-1:0] rx_rate_lo,
    input  logic              rx_en_hi,
    input  logic              rx_en_lo,
    input  logic              rx_diff,
    input  logic [RATE_W-1:0] tx_rate_hi,
    input  logic [RATE_W-1:0] tx_rate_lo,
    input  logic              tx_en_hi,
    input  logic              tx_en_lo,
    input  logic              tx_diff,
    output logic              rx_dec_valid,
    output logic              rx_dec_admit,
    output logic              tx_dec_valid,
    output logic              tx_dec_admit
);
    logic tick;

    logic [NUM_CHAN-1:0]             c_start, c_hi, c_en_hi, c_en_lo, c_diff, c_valid, c_admit;
    logic [NUM_CHAN-1:0][LEN_W-1:0]  c_len;
    logic [NUM_CHAN-1:0][RATE_W-1:0] c_rate_hi, c_rate_lo;

    assign c_start   = {tx_start, rx_start};
    assign c_hi      = {tx_hi, rx_hi};
    assign c_len     = {tx_len, rx_len};
    assign c_rate_hi = {tx_rate_hi, rx_rate_hi};
    assign c_rate_lo = {tx_rate_lo, rx_rate_lo};
    assign c_en_hi   = {tx_en_hi, rx_en_hi};
    assign c_en_lo   = {tx_en_lo, rx_en_lo};
    assign c_diff    = {tx_diff, rx_diff};

    rl_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    generate
        for (genvar i = 0; i < NUM_CHAN; i++) begin : g_chan
            rl_channel #(
                .LEN_W     (LEN_W),
                .RATE_W    (RATE_W),
                .STEP_BYTES(STEP_BYTES)
            ) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick     (tick),
                .start    (c_start[i]),
                .len      (c_len[i]),
                .hi       (c_hi[i]),
                .rate_hi  (c_rate_hi[i]),
                .rate_lo  (c_rate_lo[i]),
                .en_hi    (c_en_hi[i]),
                .en_lo    (c_en_lo[i]),
                .diff     (c_diff[i]),
                .dec_valid(c_valid[i]),
                .dec_admit(c_admit[i])
            );
        end
    endgenerate

    assign rx_dec_valid = c_valid[0];
    assign rx_dec_admit = c_admit[0];
    assign tx_dec_valid = c_valid[1];
    assign tx_dec_admit = c_admit[1];
endmodule

// File: tb/port_rate_limiter_tb.sv
module port_rate_limiter_tb;
    localparam int LEN_W = 11;
    localparam int RATE_W = 8;
    localparam int W = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_start = 0, tx_start = 0, rx_hi = 0, tx_hi = 0;
    logic [LEN_W-1:0] rx_len = '0, tx_len = '0;
    logic [RATE_W-1:0] rx_rate_hi = '0, rx_rate_lo = '0, tx_rate_hi = '0, tx_rate_lo = '0;
    logic rx_en_hi = 0, rx_en_lo = 0, rx_diff = 0, tx_en_hi = 0, tx_en_lo = 0, tx_diff = 0;
    logic rx_dec_valid, rx_dec_admit, tx_dec_valid, tx_dec_admit;

    int n_checks = 0;
    int n_fail = 0;
    int ncyc = 0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

    port_rate_limiter #(.LEN_W(LEN_W), .RATE_W(RATE_W), .STEP_BYTES(4000),
                        .WINDOW_CYCLES(W)) u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic new_window();
        @(negedge clk);
        while (ncyc % W != 0) @(negedge clk);
    endtask

    // one frame on channel ch (0 rx, 1 tx); called and returns at a negedge
    task automatic send(input int ch, input int len, input bit hi, input bit exp, input string req);
        if (ch == 0) begin rx_start = 1; rx_len = LEN_W'(len); rx_hi = hi; end
        else         begin tx_start = 1; tx_len = LEN_W'(len); tx_hi = hi; end
        @(negedge clk);
        rx_start = 0; tx_start = 0;
        check({req, " early"}, ch == 0 ? rx_dec_valid : tx_dec_valid, 0);
        @(negedge clk);
        check({req, " valid"}, ch == 0 ? rx_dec_valid : tx_dec_valid, 1);
        check({req, " admit"}, ch == 0 ? rx_dec_admit : tx_dec_admit, exp);
    endtask

    task automatic t_reset();
        check("R11 rx idle", rx_dec_valid, 0);
        check("R11 tx idle", tx_dec_valid, 0);
    endtask

    task automatic t_unlimited();
        new_window();
        rx_diff = 0; rx_en_hi = 0; rx_rate_hi = 0;
        for (int i = 0; i < 4; i++) send(0, 2000, 1, 1, "R4 unlimited");
        rx_en_hi = 1; rx_rate_hi = 1;
        send(0, 2000, 1, 1, "R4 uncounted a");
        send(0, 2000, 1, 1, "R4 uncounted b");
        send(0, 1, 1, 0, "R4 now full");
    endtask

    task automatic t_budget();
        new_window();
        rx_diff = 0; rx_en_hi = 1; rx_rate_hi = 1;
        send(0, 1500, 1, 1, "R5 first");
        send(0, 1500, 1, 1, "R5 second");
        send(0, 1500, 1, 0, "R5 over");
        send(0, 1000, 1, 1, "R7 reject added nothing, R5 equal budget");
        send(0, 1, 1, 0, "R5 one past");
    endtask

    task automatic t_zero();
        new_window();
        rx_diff = 0; rx_en_hi = 1; rx_rate_hi = 0;
        send(0, 1, 1, 0, "R6 rate zero small");
        send(0, 64, 0, 0, "R6 rate zero lo shared");
    endtask

    task automatic t_window();
        new_window();
        rx_diff = 0; rx_en_hi = 1; rx_rate_hi = 1;
        send(0, 2000, 1, 1, "R1 fill a");
        send(0, 2000, 1, 1, "R1 fill b");
        send(0, 1, 1, 0, "R1 full");
        new_window();
        send(0, 2000, 1, 1, "R1 refilled");
    endtask

    task automatic t_shared();
        new_window();
        rx_diff = 0; rx_en_hi = 1; rx_rate_hi = 1; rx_en_lo = 0; rx_rate_lo = 255;
        send(0, 2000, 0, 1, "R8 lo charged to shared");
        send(0, 1500, 1, 1, "R8 hi a");
        send(0, 1000, 1, 0, "R8 hi sees lo bytes");
        send(0, 600, 0, 0, "R8 lo governed by hi");
    endtask

    task automatic t_diff();
        new_window();
        rx_diff = 1; rx_en_hi = 1; rx_rate_hi = 1; rx_en_lo = 1; rx_rate_lo = 2;
        send(0, 2000, 1, 1, "R9 hi a");
        send(0, 2000, 1, 1, "R9 hi b");
        send(0, 1, 1, 0, "R9 hi full");
        for (int i = 0; i < 4; i++) send(0, 2000, 0, 1, "R9 lo own budget");
        send(0, 1, 0, 0, "R9 lo full");
        rx_diff = 0;
    endtask

    task automatic t_busy();
        new_window();
        rx_diff = 0; rx_en_hi = 1; rx_rate_hi = 1;
        rx_start = 1; rx_len = LEN_W'(3000); rx_hi = 1;
        @(negedge clk);
        @(negedge clk);
        rx_start = 0;
        check("R3 valid", rx_dec_valid, 1);
        check("R3 admit", rx_dec_admit, 1);
        @(negedge clk);
        check("R3 no second decision", rx_dec_valid, 0);
        send(0, 1000, 1, 1, "R3 not charged twice");
    endtask

    task automatic t_dirs();
        new_window();
        rx_diff = 0; rx_en_hi = 1; rx_rate_hi = 1;
        tx_diff = 0; tx_en_hi = 1; tx_rate_hi = 1;
        send(0, 2000, 1, 1, "R10 rx a");
        send(0, 2000, 1, 1, "R10 rx b");
        send(1, 2000, 1, 1, "R10 tx unaffected a");
        send(1, 2000, 1, 1, "R10 tx unaffected b");
        send(1, 1, 1, 0, "R10 tx full");
        check("R10 rx quiet", rx_dec_valid, 0);
    endtask

    bit done = 0;

    initial begin
        #5000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_unlimited();
        t_budget();
        t_zero();
        t_window();
        t_shared();
        t_diff();
        t_busy();
        t_dirs();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule